// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block is the front end of a rate-1/2, constraint-length-7 Viterbi decoder. Each accepted input word holds one received symbol pair, two 3-bit soft values. The block converts each soft value to a common confidence scale and then forms the distance between the received pair and each of the four possible transmitted pairs. The four metrics leave the block together in one registered word, marked by a valid strobe that follows the input strobe by one clock.

The received values can use one of two soft encodings. In the unipolar encoding the code rises from the surest 0 to the surest 1. In the bipolar encoding the sign bit marks the 0 side. A build-time parameter selects the encoding, and both are mapped to the same scale before any metric is formed, so the path metric stage after this block sees one format only.

The block also provides, as a constant bus derived from the two generator polynomials, the transmitted pair that belongs to every encoder state. The add-compare-select stage uses this bus to pick the metric for each trellis branch. Path metric accumulation and traceback belong to other blocks.

Top module: `vbm_top`

## Requirements
- R1: `sym_i[5:3]` is the soft value of the first coded bit and `sym_i[2:0]` is the soft value of the second. The metric for the hypothesised pair {first, second} = {a, b} is placed at `bm_o[4k+3:4k]` with k = 2a + b.
- R2: With `BIPOLAR_IN = 0` (unipolar), the code itself is the confidence v: 000 is the surest 0, 011 the weakest 0, 100 the weakest 1 and 111 the surest 1.
- R3: With `BIPOLAR_IN = 1` (bipolar), the codes 100, 101, 110 and 111 give v = 0, 1, 2 and 3, and the codes 000, 001, 010 and 011 give v = 4, 5, 6 and 7.
- R4: The cost of one symbol is v when the hypothesised bit is 0 and 7 − v when it is 1. A pair metric is the sum of its two symbol costs, so it lies between 0 and 14.
- R5: `bm_vld_o` is high in exactly the cycle after a cycle with `sym_vld_i` high. The four metrics of that input appear in that same cycle.
- R6: In a cycle with `sym_vld_i` low, `sym_i` is ignored. The next cycle has `bm_vld_o` low and `bm_o` unchanged.
- R7: When `rst_n` is low, `bm_vld_o` and `bm_o` go to zero at once, without waiting for a clock edge.
- R8: For an encoder state s (6 bits, with s[5] the most recent earlier input), `branch_lbl_o[2s+1]` is the parity of (octal 171 AND {0, s}) and `branch_lbl_o[2s]` is the parity of (octal 133 AND {0, s}). Together they give the pair sent when the new input bit is 0. For a new input bit of 1 both bits are inverted.
- R9: In every valid output, metric 0 plus metric 3 equals 14, and metric 1 plus metric 2 equals 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_vld_i | input | 1 | Input symbol pair is valid |
| sym_i | input | 6 | Soft pair: first value in the upper 3 bits, second value in the lower 3 bits |
| bm_vld_o | output | 1 | Branch metrics are valid |
| bm_o | output | 16 | Four 4-bit metrics; slot k holds hypothesis pair k |
| branch_lbl_o | output | 128 | Per-state transmitted pair for a new input bit of 0 |

## Verification
The bench builds the block twice on one clock: once with the default unipolar setting and once with `BIPOLAR_IN = 1`. Both copies receive the same stimulus. Sweeping all 64 soft pairs through both copies reaches every code of both mappings, and every metric from 0 to 14 in every slot, including the end points. The same two builds let the bench check the polynomial-derived state labels for all 64 states, and check hold, back-to-back and mid-stream reset behaviour on both copies.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

    // Number of hypothesised pairs for a rate-1/2 code
    localparam int unsigned HYP_N = 4;

    // Parity of a vector
    function automatic logic parity_of(input logic [31:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/vbm_soft_map.sv
// Maps one soft value onto the common confidence scale
// (0 = surest zero, all ones = surest one).
module vbm_soft_map #(
    parameter int unsigned SOFT_W     = 3,
    parameter bit          BIPOLAR_IN = 1'b0
) (
    input  logic [SOFT_W-1:0] raw_i,
    output logic [SOFT_W-1:0] conf_o
);

    generate
        if (BIPOLAR_IN) begin : g_bipolar
            // sign bit marks the zero side; inverting it yields the monotonic scale
            assign conf_o = {~raw_i[SOFT_W-1], raw_i[SOFT_W-2:0]};
        end else begin : g_unipolar
            assign conf_o = raw_i;
        end
    endgenerate

endmodule

// File: rtl/vbm_pair_cost.sv
// Forms the four pair metrics from two confidence values.
module vbm_pair_cost #(
    parameter int unsigned SOFT_W = 3,
    localparam int unsigned MW    = SOFT_W + 1
) (
    input  logic [SOFT_W-1:0]                 conf_a_i,
    input  logic [SOFT_W-1:0]                 conf_b_i,
    output logic [vbm_pkg::HYP_N-1:0][MW-1:0] cost_o
);

    localparam logic [SOFT_W-1:0] VMAX = '1;

    logic [1:0][MW-1:0] cost_a;   // index = hypothesised bit
    logic [1:0][MW-1:0] cost_b;

    always_comb begin
        cost_a[0] = {1'b0, conf_a_i};
        cost_a[1] = {1'b0, VMAX - conf_a_i};
        cost_b[0] = {1'b0, conf_b_i};
        cost_b[1] = {1'b0, VMAX - conf_b_i};
    end

    generate
        for (genvar k = 0; k < int'(vbm_pkg::HYP_N); k++) begin : g_hyp
            assign cost_o[k] = cost_a[k/2] + cost_b[k%2];
        end
    endgenerate

endmodule

// File: rtl/vbm_state_labels.sv
// Constant per-state transmitted pair for a new input bit of 0.
module vbm_state_labels #(
    parameter int unsigned      CONSTR_K = 7,
    parameter logic [CONSTR_K-1:0] POLY_A = 7'o171,
    parameter logic [CONSTR_K-1:0] POLY_B = 7'o133,
    localparam int unsigned     NSTATE   = 1 << (CONSTR_K - 1)
) (
    output logic [2*NSTATE-1:0] lbl_o
);

    generate
        for (genvar s = 0; s < int'(NSTATE); s++) begin : g_state
            // shift register contents with the new input bit (MSB) at 0
            localparam logic [CONSTR_K-1:0] REGV = CONSTR_K'(s);
            localparam logic [31:0] TAP_A = 32'(REGV & POLY_A);
            localparam logic [31:0] TAP_B = 32'(REGV & POLY_B);
            assign lbl_o[2*s+1] = vbm_pkg::parity_of(TAP_A);
            assign lbl_o[2*s]   = vbm_pkg::parity_of(TAP_B);
        end
    endgenerate

endmodule

// File: rtl/vbm_top.sv
module vbm_top #(
    parameter int unsigned SOFT_W     = 3,
    parameter bit          BIPOLAR_IN = 1'b0,
    parameter int unsigned CONSTR_K   = 7,
    parameter logic [CONSTR_K-1:0] POLY_A = 7'o171,
    parameter logic [CONSTR_K-1:0] POLY_B = 7'o133,
    localparam int unsigned MW        = SOFT_W + 1,
    localparam int unsigned NSTATE    = 1 << (CONSTR_K - 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sym_vld_i,
    input  logic [2*SOFT_W-1:0]                  sym_i,
    output logic                                 bm_vld_o,
    output logic [vbm_pkg::HYP_N*MW-1:0]         bm_o,
    output logic [2*NSTATE-1:0]                  branch_lbl_o
);

    localparam logic [MW-1:0] PAIR_SUM = MW'({1'b0, {SOFT_W{1'b1}}} << 1);

    typedef struct packed {
        logic                                 vld;
        logic [vbm_pkg::HYP_N-1:0][MW-1:0]    bm;
    } out_state_t;

    logic [SOFT_W-1:0]                 conf_a;
    logic [SOFT_W-1:0]                 conf_b;
    logic [vbm_pkg::HYP_N-1:0][MW-1:0] cost_w;
    out_state_t                        st_d;
    out_state_t                        st_q;

    vbm_soft_map #(.SOFT_W(SOFT_W), .BIPOLAR_IN(BIPOLAR_IN)) u_map_a (
        .raw_i  (sym_i[2*SOFT_W-1:SOFT_W]),
        .conf_o (conf_a)
    );

    vbm_soft_map #(.SOFT_W(SOFT_W), .BIPOLAR_IN(BIPOLAR_IN)) u_map_b (
        .raw_i  (sym_i[SOFT_W-1:0]),
        .conf_o (conf_b)
    );

    vbm_pair_cost #(.SOFT_W(SOFT_W)) u_cost (
        .conf_a_i (conf_a),
        .conf_b_i (conf_b),
        .cost_o   (cost_w)
    );

    vbm_state_labels #(.CONSTR_K(CONSTR_K), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_lbl (
        .lbl_o (branch_lbl_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = sym_vld_i;
        if (sym_vld_i) begin
            st_d.bm = cost_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bm_vld_o = st_q.vld;
    assign bm_o     = st_q.bm;

    // R5: valid follows the input strobe by exactly one clock
    p_vld_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_vld_i |=> bm_vld_o);
    p_vld_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld_i |=> !bm_vld_o);

    // R6: metrics hold across idle cycles
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld_i |=> $stable(bm_o));

    // R9: complementary hypotheses sum to the full scale
    p_comp_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bm_vld_o |-> ((MW+1)'(st_q.bm[0]) + (MW+1)'(st_q.bm[3]) == (MW+1)'(PAIR_SUM)) &&
                     ((MW+1)'(st_q.bm[1]) + (MW+1)'(st_q.bm[2]) == (MW+1)'(PAIR_SUM)));

    // R4: no metric exceeds twice the largest symbol cost
    generate
        for (genvar k = 0; k < int'(vbm_pkg::HYP_N); k++) begin : g_chk
            p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
                bm_vld_o |-> (st_q.bm[k] <= PAIR_SUM));
        end
    endgenerate

endmodule

// File: tb/tb_vbm_top.sv
module tb_vbm_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_vld_i = 1'b0;
    logic [5:0]  sym_i = '0;
    logic        vld_u, vld_b;
    logic [15:0] bm_u, bm_b;
    logic [127:0] lbl_u, lbl_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vbm_top dut (
        .clk(clk), .rst_n(rst_n), .sym_vld_i(sym_vld_i), .sym_i(sym_i),
        .bm_vld_o(vld_u), .bm_o(bm_u), .branch_lbl_o(lbl_u)
    );

    vbm_top #(.BIPOLAR_IN(1'b1)) dut_bp (
        .clk(clk), .rst_n(rst_n), .sym_vld_i(sym_vld_i), .sym_i(sym_i),
        .bm_vld_o(vld_b), .bm_o(bm_b), .branch_lbl_o(lbl_b)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int uni_conf(input logic [2:0] c);
        return int'(c);
    endfunction

    function automatic int bip_conf(input logic [2:0] c);
        if (c[2]) return int'(c[1:0]);        // zero side: 100 surest
        else      return 4 + int'(c[1:0]);    // one side: 000 weakest
    endfunction

    function automatic logic [15:0] exp_bm(input int va, input int vb);
        logic [15:0] r;
        for (int k = 0; k < 4; k++) begin
            int ca, cb;
            ca = (k / 2 == 1) ? 7 - va : va;
            cb = (k % 2 == 1) ? 7 - vb : vb;
            r[4*k +: 4] = 4'(ca + cb);
        end
        return r;
    endfunction

    task automatic t_reset();
        check("R7 reset vld unipolar", 128'(vld_u), 128'(0));
        check("R7 reset vld bipolar", 128'(vld_b), 128'(0));
        check("R7 reset metrics", 128'({bm_u, bm_b}), 128'(0));
    endtask

    task automatic t_sweep();
        for (int p = 0; p < 64; p++) begin
            logic [15:0] eu, eb;
            sym_vld_i = 1'b1;
            sym_i = 6'(p);
            eu = exp_bm(uni_conf(sym_i[5:3]), uni_conf(sym_i[2:0]));
            eb = exp_bm(bip_conf(sym_i[5:3]), bip_conf(sym_i[2:0]));
            @(negedge clk);
            check("R5 vld after input", 128'({vld_u, vld_b}), 128'(2'b11));
            check("R1 R2 R4 unipolar metrics", 128'(bm_u), 128'(eu));
            check("R3 R4 R9 bipolar metrics", 128'(bm_b), 128'(eb));
        end
        sym_vld_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_extremes();
        // surest zeros: metric 00 = 0, metric 11 = 14
        sym_vld_i = 1'b1; sym_i = 6'b000_000;
        @(negedge clk);
        check("R4 unipolar min/max", 128'(bm_u), 128'(16'hE770));
        sym_i = 6'b100_100;
        @(negedge clk);
        check("R3 bipolar surest zeros", 128'(bm_b), 128'(16'hE770));
        check("R2 unipolar weakest ones", 128'(bm_u), 128'(16'h6778));
        sym_vld_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold();
        logic [15:0] su, sb;
        sym_vld_i = 1'b1; sym_i = 6'b110_001;
        @(negedge clk);
        su = bm_u; sb = bm_b;
        sym_vld_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sym_i = 6'(7 * i + 5);
            @(negedge clk);
            check("R6 vld low when idle", 128'({vld_u, vld_b}), 128'(0));
            check("R6 metrics held unipolar", 128'(bm_u), 128'(su));
            check("R6 metrics held bipolar", 128'(bm_b), 128'(sb));
        end
    endtask

    task automatic t_single_pulse();
        sym_vld_i = 1'b1; sym_i = 6'b011_101;
        @(negedge clk);
        sym_vld_i = 1'b0;
        check("R5 pulse one cycle", 128'(vld_u), 128'(1));
        @(negedge clk);
        check("R5 pulse ends", 128'(vld_u), 128'(0));
        check("R1 slot order", 128'(bm_u), 128'(exp_bm(3, 5)));
    endtask

    task automatic t_async_reset();
        sym_vld_i = 1'b1; sym_i = 6'b111_111;
        @(negedge clk);
        sym_vld_i = 1'b0;
        #1 rst_n = 1'b0;
        #1;
        check("R7 async clear vld", 128'({vld_u, vld_b}), 128'(0));
        check("R7 async clear metrics", 128'({bm_u, bm_b}), 128'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_labels();
        logic [6:0] ga, gb;
        ga = 7'b1111001; gb = 7'b1011011;
        for (int s = 0; s < 64; s++) begin
            logic [6:0] rg;
            logic ea, eb;
            rg = {1'b0, 6'(s)};
            ea = 1'b0; eb = 1'b0;
            for (int j = 0; j < 7; j++) begin
                if (ga[j]) ea = ea ^ rg[j];
                if (gb[j]) eb = eb ^ rg[j];
            end
            check("R8 state label", 128'(lbl_u[2*s +: 2]), 128'({ea, eb}));
        end
        check("R8 label bus same in both builds", lbl_b, lbl_u);
    endtask

    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_extremes();
        t_hold();
        t_single_pulse();
        t_async_reset();
        t_labels();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule